// File: doc/BRIEF.md
# Parallel Flash Byte Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash bus. A client hands it one request: program a byte, erase the whole chip, or switch on the boot-sector lock. The block then plays the fixed unlock and command write cycles onto the bus. Strobe low and high times are counted in clocks, so they can meet the device's minimum widths at any clock rate.

After a program or an erase, the block polls the device until the internal operation ends. It uses one of two methods, selected per request. The first reads the target address until bit 7 matches the expected value. The second reads repeatedly and waits until bit 6 stops changing. A read-count limit ends a poll that never completes and reports an error. The lock request does not poll. It waits a fixed number of clocks and then reports completion.

The data bus is split into separate drive, enable and receive signals. A pad ring or a bench combines them into a bidirectional bus.

Top module: `flash_cmd_seq`

## Requirements
- R1: Reset state. After reset, `req_ready` is 1. `fl_we_n`, `fl_oe_n` and `fl_ce_n` are all 1. `fl_dq_oe` is 0 and `done` is 0.
- R2: Program. A request with `req_cmd`=2'b00 produces four write cycles, given as data→address: 0xAA→0x5555, 0x55→0x2AAA, 0xA0→0x5555, then `req_data`→`req_addr`.
- R3: Erase. A request with `req_cmd`=2'b01 produces six write cycles: 0xAA→0x5555, 0x55→0x2AAA, 0x80→0x5555, 0xAA→0x5555, 0x55→0x2AAA, 0x10→0x5555.
- R4: Lock. A request with `req_cmd`=2'b10 produces the erase sequence with a last data byte of 0x40. It performs no read. `done` follows at least `PAUSE_CYC` clocks after the last strobe rises.
- R5: Write strobe timing. Each `fl_we_n` low pulse lasts exactly `WP_CYC` clocks. Within one sequence, the strobe stays high at least `WPH_CYC` clocks between pulses. `fl_addr` and `fl_dq_out` are valid one clock before the strobe falls and do not change until the strobe has risen.
- R6: Bus direction. `fl_oe_n` is never low while `fl_we_n` is low or while `fl_dq_oe` is 1. The block drives the data bus only during write cycles.
- R7: Data polling. With `req_toggle`=0, the block reads the target address until bit 7 of the read equals bit 7 of the expected byte. For a program the expected byte is the written data. For an erase it is 0xFF. The block then pulses `done` with `err`=0.
- R8: Toggle polling. With `req_toggle`=1, the block reads the target address repeatedly. Between reads, `fl_oe_n` stays high at least `TGAP_CYC` clocks. The block finishes when bit 6 is equal in two consecutive reads.
- R9: Timeout. If `MAX_POLLS` reads pass without completion, the block pulses `done` with `err`=1 and makes no further read.
- R10: Busy. `req_ready` is 0 from acceptance until after `done`. A `req_valid` raised in that time is ignored and starts no write cycle.
- R11: `done` lasts exactly one clock. `err` is 1 only together with `done`.
- R12: Reserved command. `req_cmd`=2'b11 starts no bus cycle and completes with `done` and `err`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_cmd | input | 2 | 00 program, 01 erase, 10 lock, 11 reserved |
| req_toggle | input | 1 | Poll method: 0 bit-7 compare, 1 bit-6 toggle |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Completion was a timeout or a reserved command |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Read enable, active low |

## Verification
The hardest case to reach from the ports is toggle polling ending correctly. Bit 6 must alternate for several reads and then settle. The block must stop after two equal reads rather than after the first stable one. The bench's flash model derives its busy window from its own count of completed reads. It returns the complement of bit 7 and a bit 6 that flips on each read until the window closes, then returns the true byte. The test checks that the model's window is closed when `done` appears and that no read came too early. A model whose window never closes drives the timeout path.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        CMD_PROG  = 2'b00,
        CMD_ERASE = 2'b01,
        CMD_LOCK  = 2'b10,
        CMD_RSVD  = 2'b11
    } fl_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WLOW,
        ST_WHIGH,
        ST_RGAP,
        ST_RLOW,
        ST_PAUSE,
        ST_DONE
    } fl_state_e;

    localparam logic [14:0] UNLK_A = 15'h5555;
    localparam logic [14:0] UNLK_B = 15'h2AAA;

endpackage

// File: rtl/flash_cmd_rom.sv
// Maps (command, step) to the address/data pair of one write cycle.
module flash_cmd_rom
    import flash_seq_pkg::*;
#(
    parameter int AW = 19
) (
    input  fl_cmd_e          cmd,
    input  logic [2:0]       step,
    input  logic [AW-1:0]    tgt_addr,
    input  logic [7:0]       tgt_data,
    output logic [AW-1:0]    wr_addr,
    output logic [7:0]       wr_data,
    output logic             last
);
    localparam logic [AW-1:0] A_HI = AW'(UNLK_A);
    localparam logic [AW-1:0] A_LO = AW'(UNLK_B);

    always_comb begin
        wr_addr = A_HI;
        wr_data = 8'hAA;
        last    = 1'b0;
        if (cmd == CMD_PROG) begin
            last = (step == 3'd3);
            case (step)
                3'd0:    begin wr_addr = A_HI;     wr_data = 8'hAA;    end
                3'd1:    begin wr_addr = A_LO;     wr_data = 8'h55;    end
                3'd2:    begin wr_addr = A_HI;     wr_data = 8'hA0;    end
                default: begin wr_addr = tgt_addr; wr_data = tgt_data; end
            endcase
        end else begin
            last = (step == 3'd5);
            case (step)
                3'd0:    begin wr_addr = A_HI; wr_data = 8'hAA; end
                3'd1:    begin wr_addr = A_LO; wr_data = 8'h55; end
                3'd2:    begin wr_addr = A_HI; wr_data = 8'h80; end
                3'd3:    begin wr_addr = A_HI; wr_data = 8'hAA; end
                3'd4:    begin wr_addr = A_LO; wr_data = 8'h55; end
                default: begin
                    wr_addr = A_HI;
                    wr_data = (cmd == CMD_LOCK) ? 8'h40 : 8'h10;
                end
            endcase
        end
    end
endmodule

// File: rtl/flash_poll_eval.sv
// Decides from one read whether the internal operation has ended.
module flash_poll_eval (
    input  logic       toggle_mode,
    input  logic [7:0] rd_byte,
    input  logic [7:0] exp_byte,
    input  logic       prev_b6,
    input  logic       have_prev,
    output logic       finished
);
    always_comb begin
        if (toggle_mode) finished = have_prev && (rd_byte[6] == prev_b6);
        else             finished = (rd_byte[7] == exp_byte[7]);
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int AW        = 19,
    parameter int WP_CYC    = 5,
    parameter int WPH_CYC   = 5,
    parameter int TGAP_CYC  = 8,
    parameter int RD_CYC    = 4,
    parameter int PAUSE_CYC = 50_000_000,
    parameter int MAX_POLLS = 1_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_cmd,
    input  logic          req_toggle,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int M1 = (WP_CYC > WPH_CYC) ? WP_CYC : WPH_CYC;
    localparam int M2 = (TGAP_CYC > RD_CYC) ? TGAP_CYC : RD_CYC;
    localparam int M3 = (M1 > M2) ? M1 : M2;
    localparam int MAXC = (M3 > PAUSE_CYC) ? M3 : PAUSE_CYC;
    localparam int CW = $clog2(MAXC + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    typedef struct packed {
        fl_state_e      st;
        fl_cmd_e        cmd;
        logic           tog;
        logic [2:0]     step;
        logic [AW-1:0]  tgt;
        logic [7:0]     dat;
        logic [CW-1:0]  cnt;
        logic [PW-1:0]  polls;
        logic           prev6;
        logic           have_prev;
        logic           err;
    } seq_t;

    seq_t q, d;

    logic [AW-1:0] rom_addr;
    logic [7:0]    rom_data;
    logic          rom_last;
    logic          poll_fin;

    flash_cmd_rom #(.AW(AW)) u_rom (
        .cmd      (q.cmd),
        .step     (q.step),
        .tgt_addr (q.tgt),
        .tgt_data (q.dat),
        .wr_addr  (rom_addr),
        .wr_data  (rom_data),
        .last     (rom_last)
    );

    flash_poll_eval u_eval (
        .toggle_mode (q.tog),
        .rd_byte     (fl_dq_in),
        .exp_byte    (q.dat),
        .prev_b6     (q.prev6),
        .have_prev   (q.have_prev),
        .finished    (poll_fin)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.cmd       = fl_cmd_e'(req_cmd);
                    d.tog       = req_toggle;
                    d.tgt       = req_addr;
                    d.dat       = (fl_cmd_e'(req_cmd) == CMD_PROG) ? req_data : 8'hFF;
                    d.step      = 3'd0;
                    d.polls     = '0;
                    d.have_prev = 1'b0;
                    d.err       = (fl_cmd_e'(req_cmd) == CMD_RSVD);
                    d.st        = (fl_cmd_e'(req_cmd) == CMD_RSVD) ? ST_DONE : ST_SETUP;
                end
            end
            ST_SETUP: begin
                d.st  = ST_WLOW;
                d.cnt = CW'(WP_CYC - 1);
            end
            ST_WLOW: begin
                if (q.cnt == '0) begin
                    d.st  = ST_WHIGH;
                    d.cnt = CW'(WPH_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WHIGH: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else if (!rom_last) begin
                    d.step = q.step + 3'd1;
                    d.st   = ST_SETUP;
                end else if (q.cmd == CMD_LOCK) begin
                    d.st  = ST_PAUSE;
                    d.cnt = CW'(PAUSE_CYC - 1);
                end else begin
                    d.st  = ST_RGAP;
                    d.cnt = CW'(TGAP_CYC - 1);
                end
            end
            ST_RGAP: begin
                if (q.cnt == '0) begin
                    d.st  = ST_RLOW;
                    d.cnt = CW'(RD_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_RLOW: begin
                if (q.cnt != '0) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.polls     = q.polls + 1'b1;
                    d.prev6     = fl_dq_in[6];
                    d.have_prev = 1'b1;
                    if (poll_fin) begin
                        d.st = ST_DONE;
                    end else if (q.polls == PW'(MAX_POLLS - 1)) begin
                        d.st  = ST_DONE;
                        d.err = 1'b1;
                    end else begin
                        d.st  = ST_RGAP;
                        d.cnt = CW'(TGAP_CYC - 1);
                    end
                end
            end
            ST_PAUSE: begin
                if (q.cnt == '0) d.st = ST_DONE;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.cmd   <= CMD_PROG;
        end else begin
            q <= d;
        end
    end

    logic in_write;
    assign in_write  = (q.st == ST_SETUP) || (q.st == ST_WLOW) || (q.st == ST_WHIGH);
    assign req_ready = (q.st == ST_IDLE);
    assign done      = (q.st == ST_DONE);
    assign err       = done && q.err;
    assign fl_we_n   = (q.st != ST_WLOW);
    assign fl_oe_n   = (q.st != ST_RLOW);
    assign fl_ce_n   = !(in_write || (q.st == ST_RGAP) || (q.st == ST_RLOW));
    assign fl_dq_oe  = in_write;
    assign fl_dq_out = rom_data;
    assign fl_addr   = in_write ? rom_addr : q.tgt;

    // Strobe width counter used only by the timing check below.
    logic [CW-1:0] we_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        we_low_q <= '0;
        else if (!fl_we_n) we_low_q <= we_low_q + 1'b1;
        else               we_low_q <= '0;
    end

    // R5
    we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_we_n) |-> (we_low_q == CW'(WP_CYC)));

    // R5
    wr_bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> ($stable(fl_addr) && $stable(fl_dq_out)));

    // R6
    no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (fl_we_n && !fl_dq_oe));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_ce_n |-> !req_ready);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 19;
    localparam int WP    = 3;
    localparam int WPH   = 3;
    localparam int TGAP  = 4;
    localparam int RDC   = 2;
    localparam int PAUSE = 40;
    localparam int MAXP  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_cmd = 2'b00;
    logic req_toggle = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic req_ready, done, err;
    logic [AW-1:0] fl_addr;
    logic [7:0] fl_dq_out, fl_dq_in;
    logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq #(
        .AW(AW), .WP_CYC(WP), .WPH_CYC(WPH), .TGAP_CYC(TGAP),
        .RD_CYC(RDC), .PAUSE_CYC(PAUSE), .MAX_POLLS(MAXP)
    ) u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_toggle(req_toggle), .req_addr(req_addr),
        .req_data(req_data), .done(done), .err(err), .fl_addr(fl_addr),
        .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int checks = 0;
    int errors = 0;

    // Flash model settings written by the tasks only.
    int rd_base = 0;
    int busy_lim = 0;
    logic [7:0] mval = 8'hFF;

    // Monitor state, written by the monitor only.
    int cyc = 0, nw = 0, nr = 0;
    int lo_len = 0, hi_len = 0, gap = 0, last_rise = 0;
    int v_width = 0, v_gap = 0, v_stab = 0, v_oe = 0, v_rgap = 0, v_drv = 0;
    logic prev_we = 1'b1, prev_oe = 1'b1;
    logic [AW-1:0] fall_a;
    logic [7:0] fall_d;
    logic [AW-1:0] wa [0:63];
    logic [7:0] wd [0:63];

    logic busy;
    assign busy = (nr - rd_base) < busy_lim;
    assign fl_dq_in = busy ? {~mval[7], nr[0], mval[5:0]} : mval;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (fl_dq_oe && !fl_oe_n) v_drv++;
            if (!fl_we_n) begin
                if (!fl_oe_n) v_oe++;
                if (prev_we) begin
                    if (hi_len > 0 && hi_len < WPH && !fl_ce_n) v_gap++;
                    fall_a = fl_addr; fall_d = fl_dq_out; lo_len = 1;
                end else begin
                    lo_len++;
                    if (fl_addr != fall_a || fl_dq_out != fall_d) v_stab++;
                end
            end else begin
                if (!prev_we) begin
                    if (lo_len != WP) v_width++;
                    if (nw < 64) begin wa[nw] = fl_addr; wd[nw] = fl_dq_out; end
                    nw++;
                    last_rise = cyc;
                    hi_len = 1;
                end else if (fl_ce_n) hi_len = 0;
                else if (hi_len > 0) hi_len++;
            end
            if (!fl_oe_n) begin
                if (prev_oe && nr > 0 && gap < TGAP && gap > 0) v_rgap++;
            end else if (!prev_oe) begin
                nr++;
                gap = 1;
            end else if (fl_ce_n) gap = 0;
            else if (gap > 0) gap++;
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_a(input logic [1:0] c, input int i, input logic [AW-1:0] t);
        if (c == 2'b00 && i == 3) return t;
        if (i == 1 || i == 4) return AW'(15'h2AAA);
        return AW'(15'h5555);
    endfunction

    function automatic logic [7:0] exp_d(input logic [1:0] c, input int i, input logic [7:0] v);
        case (i)
            0, 3: return (c == 2'b00 && i == 3) ? v : 8'hAA;
            1, 4: return 8'h55;
            2:    return (c == 2'b00) ? 8'hA0 : 8'h80;
            default: return (c == 2'b10) ? 8'h40 : 8'h10;
        endcase
    endfunction

    int w0, r0, done_cyc;
    logic got_err;
    logic ready_seen;

    task automatic run_req(input logic [1:0] c, input logic tg, input logic [AW-1:0] a,
                           input logic [7:0] dv, input int blim, input logic [7:0] fin,
                           input logic poke);
        int n;
        @(negedge clk);
        rd_base = nr; busy_lim = blim; mval = fin;
        w0 = nw; r0 = nr;
        req_cmd = c; req_toggle = tg; req_addr = a; req_data = dv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ready_seen = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            req_cmd = 2'b01; req_valid = 1'b1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                if (req_ready) ready_seen = 1'b1;
            end
            req_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        done_cyc = cyc;
        got_err = err;
        @(negedge clk);
        check(!done, "R11 done width", done, 0);
    endtask

    task automatic check_seq(input logic [1:0] c, input logic [AW-1:0] a, input logic [7:0] dv,
                             input int cnt, input string tag);
        check(nw - w0 == cnt, tag, nw - w0, cnt);
        for (int i = 0; i < cnt && i < nw - w0; i++) begin
            check(wa[w0+i] == exp_a(c, i, a), tag, int'(wa[w0+i]), int'(exp_a(c, i, a)));
            check(wd[w0+i] == exp_d(c, i, dv), tag, wd[w0+i], exp_d(c, i, dv));
        end
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(fl_we_n && fl_oe_n && fl_ce_n, "R1 strobes", {fl_we_n, fl_oe_n, fl_ce_n}, 7);
        check(!fl_dq_oe && !done, "R1 drive/done", {fl_dq_oe, done}, 0);
    endtask

    task automatic t_prog_datapoll(input logic [7:0] dv);
        run_req(2'b00, 1'b0, 19'h4_1234 ^ AW'(dv), dv, 3, dv, 1'b0);
        check_seq(2'b00, 19'h4_1234 ^ AW'(dv), dv, 4, "R2 program seq");
        check(!got_err, "R7 data poll err", got_err, 0);
        check(nr - r0 == 4, "R7 data poll reads", nr - r0, 4);
    endtask

    task automatic t_prog_toggle();
        run_req(2'b00, 1'b1, 19'h0_0777, 8'h5A, 5, 8'h5A, 1'b0);
        check_seq(2'b00, 19'h0_0777, 8'h5A, 4, "R2 program seq toggle");
        check(!got_err, "R8 toggle err", got_err, 0);
        check((nr - rd_base) >= busy_lim + 2 || (nr - rd_base) == busy_lim + 1,
              "R8 toggle ended after busy", nr - rd_base, busy_lim + 1);
        check(v_rgap == 0, "R8 read gap", v_rgap, 0);
    endtask

    task automatic t_erase();
        run_req(2'b01, 1'b0, 19'h7_0000, 8'h00, 6, 8'hFF, 1'b0);
        check_seq(2'b01, 19'h7_0000, 8'h00, 6, "R3 erase seq");
        check(!got_err && nr - r0 == 7, "R7 erase poll reads", nr - r0, 7);
    endtask

    task automatic t_lock();
        run_req(2'b10, 1'b0, 19'h0_0000, 8'h00, 0, 8'hFF, 1'b0);
        check_seq(2'b10, 19'h0_0000, 8'h00, 6, "R4 lock seq");
        check(nr == r0, "R4 no reads", nr - r0, 0);
        check(done_cyc - last_rise >= PAUSE, "R4 pause", done_cyc - last_rise, PAUSE);
        check(!got_err, "R4 err", got_err, 0);
    endtask

    task automatic t_timeout();
        run_req(2'b00, 1'b0, 19'h1_0001, 8'h33, 1000, 8'h33, 1'b0);
        check(got_err == 1'b1, "R9 timeout err", got_err, 1);
        check(nr - r0 == MAXP, "R9 read count", nr - r0, MAXP);
        repeat (20) @(negedge clk);
        check(nr - r0 == MAXP, "R9 no further reads", nr - r0, MAXP);
    endtask

    task automatic t_busy_ignore();
        run_req(2'b00, 1'b0, 19'h2_2222, 8'hC3, 2, 8'hC3, 1'b1);
        check(!ready_seen, "R10 ready low while busy", ready_seen, 0);
        repeat (30) @(negedge clk);
        check(nw - w0 == 4, "R10 valid ignored", nw - w0, 4);
    endtask

    task automatic t_reserved();
        run_req(2'b11, 1'b0, 19'h0_0001, 8'h01, 0, 8'hFF, 1'b0);
        check(got_err == 1'b1, "R12 reserved err", got_err, 1);
        check(nw == w0 && nr == r0, "R12 no bus cycle", nw - w0 + nr - r0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prog_datapoll(8'h35);
        t_prog_datapoll(8'hC3);
        t_prog_toggle();
        t_erase();
        t_lock();
        t_timeout();
        t_busy_ignore();
        t_reserved();
        check(v_width == 0, "R5 strobe low width", v_width, 0);
        check(v_gap == 0, "R5 strobe high gap", v_gap, 0);
        check(v_stab == 0, "R5 addr/data stable", v_stab, 0);
        check(v_oe == 0 && v_drv == 0, "R6 read enable during write", v_oe + v_drv, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule